// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is an 8-bit up-counting timer that produces a pulse-width-modulated output. It keeps two compare values: a period value N and a duty value M. A single comparator serves both values. It checks the counter against N first. When that match occurs it switches to M. When M matches it switches back to N. Each time the counter reaches N, the counter wraps to zero, the output becomes active and a one-clock interrupt pulse is issued. When the counter reaches M, the output returns to inactive.

The count advances on clock-enable ticks. A free-running power-of-two divider produces these ticks, and a 3-bit select field chooses the tap. Counting takes place only while the enable input is high and the mode field selects PWM operation. Software-style write strobes load the two compare values. The period value is protected while the timer runs. A duty value written during a period waits for the next period boundary. The pin level can be inverted and can be gated off.

Top module: `pwm_timer_h`

## Requirements
- R1: The counter advances only while `cnt_en_i` is 1 and `mode_i` equals 2'b10. Otherwise the counter and output stage hold their idle state, no interrupt is raised and the pin stays at its inactive level.
- R2: A select value k on `clk_sel_i` gives one count every 2^k clock cycles. The divider restarts together with the counter.
- R3: Once running, the period is N+1 counts, N being the period register. Exactly one `irq_o` pulse occurs per period, and it is one clock wide.
- R4: The output is active for M+1 counts, beginning at the period match, where M is the duty value in force for that period.
- R5: When counting is enabled, the counter starts from 0 and the output stays inactive during the first period. With enable sampled high at clock edge E, the first interrupt follows edge E+(N+1)*2^k-1.
- R6: Writes to the period register while `cnt_en_i` is 1 are ignored. Writes made while `cnt_en_i` is 0 are taken.
- R7: A duty write is accepted at any time, but it only takes effect from the next period match. The period in progress keeps its width.
- R8: With `out_inv_i` at 0 the active pin level is 1. With `out_inv_i` at 1 the active pin level is 0 and the inactive level is 1.
- R9: With `out_en_i` at 0 the pin holds the inactive level, which equals `out_inv_i`. Counting and interrupts carry on.
- R10: After reset the period register holds 0xFF, the duty register holds 0x00, `irq_o` is 0 and the active level is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| clk_sel_i | input | 3 | Divider tap select, divide by 2^k |
| out_en_i | input | 1 | Pin drive enable |
| out_inv_i | input | 1 | Active-low output when 1 |
| mode_i | input | 2 | Mode field; 2'b10 selects PWM |
| cyc_we_i | input | 1 | Period register write strobe |
| cyc_wdata_i | input | 8 | Period value N |
| duty_we_i | input | 1 | Duty register write strobe |
| duty_wdata_i | input | 8 | Duty value M |
| tmr_o | output | 1 | Timer output pin |
| irq_o | output | 1 | One-clock pulse at each period match |

## Verification
Every legal pair with N from 1 to 8 and M below N is run with an undivided clock. This sweep separates off-by-one errors in the period from off-by-one errors in the width, including the extreme cases M=0 and M=N-1. Extremes with N=255 confirm that the full counter range is used. A fixed pair is then repeated at all eight divider taps, which shows that the tick scales both the period and the width. Separate runs cover the following: a duty rewrite during a period, in both the growing and the shrinking direction, to show the one-period delay; a period rewrite while running, followed by a restart, to show that the write was dropped; inverted and disabled pins; and non-PWM mode values, which must produce no activity.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [1:0] MODE_PWM = 2'b10;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned SEL_W = 3;

  typedef enum logic {
    CMP_CYC  = 1'b0,
    CMP_DUTY = 1'b1
  } cmp_sel_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NUM_TAPS = 1 << SEL_W;
  localparam int unsigned DIV_W    = NUM_TAPS - 1;

  logic [DIV_W-1:0]    div_q;
  logic [NUM_TAPS-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // tap k fires when the low k divider bits are all ones
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    if (i == 0) begin : g_direct
      assign tap[i] = 1'b1;
    end else begin : g_div
      assign tap[i] = &div_q[i-1:0];
    end
  end

  assign tick_o = run_i & tap[sel_i];
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             cyc_we_i,
  input  logic [CNT_W-1:0] cyc_wdata_i,
  input  logic             duty_we_i,
  input  logic [CNT_W-1:0] duty_wdata_i,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] duty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o  <= '1;
      duty_o <= '0;
    end else begin
      if (cyc_we_i && !cnt_en_i) cyc_o <= cyc_wdata_i;
      if (duty_we_i)             duty_o <= duty_wdata_i;
    end
  end
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             lvl_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] duty_act_o
);
  cmp_sel_e         sel_q;
  logic [CNT_W-1:0] cmp_val;
  logic             hit;

  assign cmp_val = (sel_q == CMP_CYC) ? cyc_i : duty_act_o;
  assign hit     = (cnt_o == cmp_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      sel_q      <= CMP_CYC;
      lvl_o      <= 1'b0;
      irq_o      <= 1'b0;
      duty_act_o <= '0;
    end else begin
      irq_o <= 1'b0;
      if (!run_i) begin
        cnt_o      <= '0;
        sel_q      <= CMP_CYC;
        lvl_o      <= 1'b0;
        duty_act_o <= duty_i;
      end else if (tick_i) begin
        if (hit && sel_q == CMP_CYC) begin
          cnt_o      <= '0;
          lvl_o      <= 1'b1;
          irq_o      <= 1'b1;
          sel_q      <= CMP_DUTY;
          duty_act_o <= duty_i;  // new duty only at period boundary
        end else begin
          cnt_o <= cnt_o + 1'b1;
          if (hit) begin
            lvl_o <= 1'b0;
            sel_q <= CMP_CYC;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwm_out.sv
module pwm_out (
  input  logic lvl_i,
  input  logic out_en_i,
  input  logic out_inv_i,
  output logic pin_o
);
  always_comb begin
    if (out_en_i) pin_o = lvl_i ^ out_inv_i;
    else          pin_o = out_inv_i;
  end
endmodule

// File: rtl/pwm_timer_h.sv
module pwm_timer_h
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             out_en_i,
  input  logic             out_inv_i,
  input  logic [1:0]       mode_i,
  input  logic             cyc_we_i,
  input  logic [CNT_W-1:0] cyc_wdata_i,
  input  logic             duty_we_i,
  input  logic [CNT_W-1:0] duty_wdata_i,
  output logic             tmr_o,
  output logic             irq_o
);
  logic             run;
  logic             tick;
  logic             lvl;
  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] duty_act;

  assign run = cnt_en_i && (mode_i == MODE_PWM);

  pwm_prescaler #(.SEL_W(SEL_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sel_i  (clk_sel_i),
    .tick_o (tick)
  );

  pwm_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cnt_en_i     (cnt_en_i),
    .cyc_we_i     (cyc_we_i),
    .cyc_wdata_i  (cyc_wdata_i),
    .duty_we_i    (duty_we_i),
    .duty_wdata_i (duty_wdata_i),
    .cyc_o        (cyc_q),
    .duty_o       (duty_q)
  );

  pwm_core #(.CNT_W(CNT_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tick_i     (tick),
    .cyc_i      (cyc_q),
    .duty_i     (duty_q),
    .lvl_o      (lvl),
    .irq_o      (irq_o),
    .cnt_o      (cnt_q),
    .duty_act_o (duty_act)
  );

  pwm_out i_out (
    .lvl_i     (lvl),
    .out_en_i  (out_en_i),
    .out_inv_i (out_inv_i),
    .pin_o     (tmr_o)
  );
endmodule

// File: rtl/pwm_timer_h_chk.sv
module pwm_timer_h_chk
  import pwm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             run,
  input logic             irq_o,
  input logic             lvl,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cyc_q,
  input logic [CNT_W-1:0] duty_act
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (cnt_q == '0) && !lvl && !irq_o); // R1

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R3

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> cnt_q <= cyc_q); // R3

  AST_IRQ_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> lvl); // R4

  AST_CYC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cnt_en_i) |-> $stable(cyc_q)); // R6

  AST_DUTY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && !irq_o) |-> $stable(duty_act)); // R7
endmodule

bind pwm_timer_h pwm_timer_h_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .run      (run),
  .irq_o    (irq_o),
  .lvl      (lvl),
  .cnt_q    (cnt_q),
  .cyc_q    (cyc_q),
  .duty_act (duty_act)
);

// File: tb/test_pwm_timer_h.sv
module test_pwm_timer_h;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [2:0] clk_sel = '0;
  logic       out_en = 1'b1;
  logic       out_inv = 1'b0;
  logic [1:0] mode = 2'b10;
  logic       cyc_we = 1'b0;
  logic [7:0] cyc_wdata = '0;
  logic       duty_we = 1'b0;
  logic [7:0] duty_wdata = '0;
  logic       tmr;
  logic       irq;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pwm_timer_h i_pwm_timer_h (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cnt_en_i     (cnt_en),
    .clk_sel_i    (clk_sel),
    .out_en_i     (out_en),
    .out_inv_i    (out_inv),
    .mode_i       (mode),
    .cyc_we_i     (cyc_we),
    .cyc_wdata_i  (cyc_wdata),
    .duty_we_i    (duty_we),
    .duty_wdata_i (duty_wdata),
    .tmr_o        (tmr),
    .irq_o        (irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int n, input int m, input int sel);
    @(negedge clk);
    cnt_en = 1'b0; clk_sel = sel[2:0];
    cyc_we = 1'b1; cyc_wdata = n[7:0];
    duty_we = 1'b1; duty_wdata = m[7:0];
    @(negedge clk);
    cyc_we = 1'b0; duty_we = 1'b0;
    cnt_en = 1'b1;
  endtask

  task automatic restart();
    @(negedge clk);
    cnt_en = 1'b0;
    @(negedge clk);
    cnt_en = 1'b1;
  endtask

  // sample index 0 is the negedge after the first enabled posedge
  task automatic measure(input int d, input int n, input int m, input int m2,
                         input int cyc_wr, input string tag);
    int irq_idx[3];
    int nirq = 0;
    int act_pre = 0, act1 = 0, act2 = 0;
    int lim = 3 * (n + 1) * d + 8;
    bit a;
    for (int k = 0; k < 3; k++) irq_idx[k] = -1;
    for (int idx = 0; idx < lim && nirq < 3; idx++) begin
      @(negedge clk);
      duty_we = 1'b0; cyc_we = 1'b0;
      if (irq) begin
        if (nirq < 3) irq_idx[nirq] = idx;
        nirq++;
      end
      a = (tmr != out_inv);
      if (nirq == 0 && a) act_pre++;
      else if (nirq == 1 && a) act1++;
      else if (nirq == 2 && a) act2++;
      if (irq && nirq == 1) begin
        if (m2 != m) begin duty_we = 1'b1; duty_wdata = m2[7:0]; end
        if (cyc_wr >= 0) begin cyc_we = 1'b1; cyc_wdata = cyc_wr[7:0]; end
      end
    end
    chk(nirq == 3, {tag, " R3 irq count"}, nirq, 3);
    chk(irq_idx[0] == (n + 1) * d - 1, {tag, " R5 first irq"}, irq_idx[0], (n + 1) * d - 1);
    chk(act_pre == 0, {tag, " R5 first period inactive"}, act_pre, 0);
    chk(irq_idx[1] - irq_idx[0] == (n + 1) * d, {tag, " R3 period"},
        irq_idx[1] - irq_idx[0], (n + 1) * d);
    chk(irq_idx[2] - irq_idx[1] == (n + 1) * d, {tag, " R3 period 2"},
        irq_idx[2] - irq_idx[1], (n + 1) * d);
    chk(act1 == (m + 1) * d, {tag, " R4 width"}, act1, (m + 1) * d);
    chk(act2 == (m2 + 1) * d, {tag, " R7 width 2"}, act2, (m2 + 1) * d);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : stim
    int cnt_irq, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tmr == 1'b0, "R10 reset pin", tmr, 0);
    chk(irq == 1'b0, "R10 reset irq", irq, 0);

    // R10: reset values N=0xFF, M=0
    cnt_en = 1'b1;
    measure(1, 255, 0, 0, -1, "R10");

    // R3 R4 sweep over all legal small pairs
    for (int n = 1; n <= 8; n++)
      for (int m = 0; m < n; m++) begin
        cfg(n, m, 0);
        measure(1, n, m, m, -1, "R4 sweep");
      end
    cfg(255, 254, 0); measure(1, 255, 254, 254, -1, "R3 max");
    cfg(255, 0, 0);   measure(1, 255, 0, 0, -1, "R3 max min");

    // R2 every divider tap
    for (int s = 0; s < 8; s++) begin
      cfg(3, 1, s);
      measure(1 << s, 3, 1, 1, -1, "R2 tap");
    end

    // R7 duty rewrite mid-period, grow and shrink
    cfg(9, 2, 0); measure(1, 9, 2, 6, -1, "R7 grow");
    cfg(9, 7, 0); measure(1, 9, 7, 0, -1, "R7 shrink");

    // R6 period write while running is dropped
    cfg(5, 1, 0); measure(1, 5, 1, 1, 2, "R6 running write");
    restart();    measure(1, 5, 1, 1, -1, "R6 after restart");
    cfg(2, 1, 0); measure(1, 2, 1, 1, -1, "R6 idle write");

    // R8 inversion
    @(negedge clk); cnt_en = 1'b0; out_inv = 1'b1;
    @(negedge clk);
    chk(tmr == 1'b1, "R8 idle level inverted", tmr, 1);
    cfg(4, 1, 0); measure(1, 4, 1, 1, -1, "R8 inverted");

    // R9 pin disabled, counting continues
    cfg(3, 1, 0);
    out_en = 1'b0;
    cnt_irq = 0; bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq) cnt_irq++;
      if (tmr != out_inv) bad++;
    end
    chk(bad == 0, "R9 pin inactive", bad, 0);
    chk(cnt_irq == 5, "R9 irq continues", cnt_irq, 5);
    out_en = 1'b1; out_inv = 1'b0;

    // R1 non-PWM modes and disabled count
    for (int md = 0; md < 4; md++) begin
      if (md == 2) continue;
      mode = md[1:0];
      cfg(3, 1, 0);
      cnt_irq = 0; bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (irq) cnt_irq++;
        if (tmr != out_inv) bad++;
      end
      chk(cnt_irq == 0, "R1 mode irq", cnt_irq, 0);
      chk(bad == 0, "R1 mode pin", bad, 0);
    end
    mode = 2'b10;
    cfg(3, 2, 0);
    repeat (6) @(negedge clk);
    cnt_en = 1'b0;
    cnt_irq = 0; bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq) cnt_irq++;
      if (tmr != out_inv) bad++;
    end
    chk(cnt_irq == 0, "R1 stopped irq", cnt_irq, 0);
    chk(bad == 0, "R1 stopped pin", bad, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule